// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block keeps a 4 KB configuration space in a private RAM and manages the linked chain of extended capability headers inside it. Each header is one 32-bit dword that names a capability, gives its version and points at the next header. The chain always starts at byte offset 0x100. If the dword at 0x100 is zero, the chain is empty.

Two commands are issued on a single-cycle request. A lookup walks the chain for a 16-bit capability ID. It returns the byte offset of the matching header, its version and the offset of the header before it. An append links a new header in. At offset 0x100 it replaces the head while keeping the existing link. At any other offset it walks to the last entry, points that entry at the new offset and writes the new header as the end of the chain. The block touches the RAM at most once per cycle. It raises `busy` while working and pulses `done` for one cycle with the result.

Top module: `ecap_walker`

## Requirements
- R1: A header packs the capability ID in bits [15:0], the version in bits [19:16] and the next byte offset in bits [31:20]. A successful lookup returns the version stored with the matching header on `res_ver`.
- R2: When the dword at 0x100 is zero (the state after reset), a lookup reports `found`=0, `error`=0, `res_offset`=0 and `res_prev`=0.
- R3: A lookup for an ID present in the chain reports `found`=1, the header's byte offset on `res_offset` and the offset of the preceding header on `res_prev` (0 for the head at 0x100).
- R4: A lookup for an ID that is absent walks to the end of the chain and reports `found`=0, `res_offset`=0 and `res_prev` equal to the offset of the last header.
- R5: ID 0 is reserved and never matches, so a lookup for ID 0 always returns the offset of the last header on `res_prev` with `found`=0.
- R6: An append at offset 0x100 writes the new ID and version there and keeps the next pointer already held at 0x100. The old head ID then stops matching and the rest of the chain stays reachable. Results are `res_offset`=0x100 and `res_prev`=0.
- R7: An append at any other offset sets the last header's next field to the new offset, keeping that header's ID and version. It then writes the new header with a next field of 0. Results are `res_offset` = new offset and `res_prev` = old last offset.
- R8: An append is rejected with `error`=1 and leaves the chain unchanged in any of these cases: the offset is below 0x100, the offset is not a multiple of 4, the size is below 8, or offset plus size reaches 0x1000.
- R9: An append at an offset other than 0x100 while the chain is empty is rejected with `error`=1.
- R10: A walk that would read more than STEP_LIMIT headers stops with `error`=1, `found`=0 and both offsets 0. The same applies to a walk that meets a next pointer that is unaligned or outside 0x100..0xFF8.
- R11: `busy` is high from the cycle after a request is accepted until `done`. `done` is high for exactly one cycle. A request raised while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Request strobe, taken when `busy` is low |
| cmd_op | input | 1 | 0 = lookup, 1 = append |
| cmd_id | input | 16 | Capability ID to look up or to append |
| cmd_ver | input | 4 | Version for an append |
| cmd_offset | input | 12 | Byte offset for an append |
| cmd_size | input | 13 | Byte size of the appended capability |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Lookup matched |
| error | output | 1 | Command failed |
| res_offset | output | 12 | Matching or appended header offset |
| res_prev | output | 12 | Preceding or last header offset |
| res_ver | output | 4 | Version of the matched header |

## Verification
The bench builds a chain whose offsets run downward through the space, so a walker that assumed ascending links would return wrong predecessors. It then looks up every ID and checks offset, predecessor and version against a model list. It probes the exact reject edges: 0xFC, an unaligned offset, a size of 7, and an end at exactly 0x1000. A design with an off-by-one there would accept or wrongly refuse. A small step limit catches a guard that counts one header too few or too many: the entry at the limit must be found and the one past it must fail. Re-writing the head checks that the link survives. A design that cleared it would lose the whole chain on the next lookup.

// File: rtl/ecw_pkg.sv
package ecw_pkg;
    localparam int ID_W  = 16;
    localparam int VER_W = 4;
    localparam int PTR_W = 12;
    localparam int HDR_W = ID_W + VER_W + PTR_W;

    typedef enum logic [2:0] {
        S_IDLE, S_READ, S_CHECK, S_LINK, S_WRITE, S_DONE
    } ecw_state_e;

    function automatic logic [HDR_W-1:0] hdr_pack(
        input logic [ID_W-1:0] id, input logic [VER_W-1:0] ver,
        input logic [PTR_W-1:0] nxt);
        return {nxt, ver, id};
    endfunction
endpackage

// File: rtl/ecw_cfg_ram.sv
module ecw_cfg_ram #(
    parameter int AW = 12,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata
);
    localparam int IW    = AW - 2;
    localparam int DEPTH = 1 << IW;

    logic [DW-1:0]    mem [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [DW-1:0]    rdata_q;

    // Storage without reset; a per-word written flag makes fresh words read zero.
    always_ff @(posedge clk) begin
        if (we) mem[waddr[AW-1:2]] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (we) vld_q[waddr[AW-1:2]] <= 1'b1;
            if (re) rdata_q <= vld_q[raddr[AW-1:2]] ? mem[raddr[AW-1:2]] : '0;
        end
    end

    assign rdata = rdata_q;

    // One access per cycle
    p_single_port_r11: assert property (@(posedge clk) disable iff (!rst_n) !(re && we));
endmodule

// File: rtl/ecw_cmd_check.sv
module ecw_cmd_check #(
    parameter int PW       = 12,
    parameter int SW       = 13,
    parameter int BASE_OFF = 256,
    parameter int SPACE    = 4096,
    parameter int MIN_SIZE = 8
) (
    input  logic [PW-1:0] offset,
    input  logic [SW-1:0] size,
    output logic          bad
);
    localparam int XW = (PW > SW ? PW : SW) + 1;
    logic [XW-1:0] end_x;

    always_comb begin
        end_x = XW'(offset) + XW'(size);
        bad   = (offset < PW'(BASE_OFF)) || (offset[1:0] != 2'b00) ||
                (size < SW'(MIN_SIZE)) || (end_x >= XW'(SPACE));
    end
endmodule

// File: rtl/ecap_walker.sv
module ecap_walker
    import ecw_pkg::*;
#(
    parameter int BASE_OFF   = 256,
    parameter int TOP_OFF    = 4088,
    parameter int SPACE      = 4096,
    parameter int STEP_LIMIT = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_op,
    input  logic [ID_W-1:0]  cmd_id,
    input  logic [VER_W-1:0] cmd_ver,
    input  logic [PTR_W-1:0] cmd_offset,
    input  logic [12:0]      cmd_size,
    output logic             busy,
    output logic             done,
    output logic             found,
    output logic             error,
    output logic [PTR_W-1:0] res_offset,
    output logic [PTR_W-1:0] res_prev,
    output logic [VER_W-1:0] res_ver
);
    localparam int STEP_W = $clog2(STEP_LIMIT) + 1;
    localparam logic [PTR_W-1:0]  BASE_A  = PTR_W'(BASE_OFF);
    localparam logic [PTR_W-1:0]  TOP_A   = PTR_W'(TOP_OFF);
    localparam logic [STEP_W-1:0] LAST_ST = STEP_W'(STEP_LIMIT - 1);

    typedef struct packed {
        ecw_state_e       st;
        logic             op;
        logic             head;
        logic [ID_W-1:0]  key;
        logic [ID_W-1:0]  app_id;
        logic [VER_W-1:0] ver;
        logic [PTR_W-1:0] new_off;
        logic [PTR_W-1:0] cur;
        logic [PTR_W-1:0] prev;
        logic [STEP_W-1:0] steps;
        logic [HDR_W-1:0] tail_hdr;
        logic             done;
        logic             found;
        logic             err;
        logic [PTR_W-1:0] r_off;
        logic [PTR_W-1:0] r_prev;
        logic [VER_W-1:0] r_ver;
    } walk_t;

    walk_t q, d;

    logic             ram_re, ram_we;
    logic [PTR_W-1:0] ram_waddr;
    logic [HDR_W-1:0] ram_wdata, ram_rdata;
    logic             app_bad;
    logic [ID_W-1:0]  h_id;
    logic [VER_W-1:0] h_ver;
    logic [PTR_W-1:0] h_nxt;

    ecw_cfg_ram #(.AW(PTR_W), .DW(HDR_W)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .re(ram_re), .raddr(q.cur), .rdata(ram_rdata),
        .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata)
    );

    ecw_cmd_check #(.PW(PTR_W), .SW(13), .BASE_OFF(BASE_OFF), .SPACE(SPACE), .MIN_SIZE(8)) u_chk (
        .offset(cmd_offset), .size(cmd_size), .bad(app_bad)
    );

    assign h_id  = ram_rdata[ID_W-1:0];
    assign h_ver = ram_rdata[ID_W+VER_W-1:ID_W];
    assign h_nxt = ram_rdata[HDR_W-1:ID_W+VER_W];

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        ram_re    = 1'b0;
        ram_we    = 1'b0;
        ram_waddr = '0;
        ram_wdata = '0;
        unique case (q.st)
            S_IDLE: if (cmd_valid) begin
                d.op      = cmd_op;
                d.app_id  = cmd_id;
                d.key     = cmd_op ? '0 : cmd_id;   // append walks with reserved ID 0
                d.ver     = cmd_ver;
                d.new_off = cmd_offset;
                d.cur     = BASE_A;
                d.prev    = '0;
                d.steps   = '0;
                d.found   = 1'b0;
                d.err     = 1'b0;
                d.r_off   = '0;
                d.r_prev  = '0;
                d.r_ver   = '0;
                d.head    = cmd_op && (cmd_offset == BASE_A);
                if (cmd_op && app_bad) begin
                    d.err  = 1'b1;
                    d.st   = S_DONE;
                    d.done = 1'b1;
                end else begin
                    d.st = S_READ;
                end
            end
            S_READ: begin
                ram_re = 1'b1;
                d.st   = S_CHECK;
            end
            S_CHECK: begin
                if (q.head) begin
                    d.tail_hdr = ram_rdata;
                    d.r_off    = BASE_A;
                    d.st       = S_WRITE;
                end else if (q.cur == BASE_A && ram_rdata == '0) begin
                    d.err  = q.op;              // empty chain: lookup misses, append fails
                    d.st   = S_DONE;
                    d.done = 1'b1;
                end else if (q.key != '0 && h_id == q.key) begin
                    d.found  = 1'b1;
                    d.r_off  = q.cur;
                    d.r_prev = q.prev;
                    d.r_ver  = h_ver;
                    d.st     = S_DONE;
                    d.done   = 1'b1;
                end else if (h_nxt == '0) begin
                    d.r_prev = q.cur;
                    if (q.op) begin
                        d.tail_hdr = ram_rdata;
                        d.r_off    = q.new_off;
                        d.st       = S_LINK;
                    end else begin
                        d.st   = S_DONE;
                        d.done = 1'b1;
                    end
                end else if (h_nxt[1:0] != 2'b00 || h_nxt < BASE_A || h_nxt > TOP_A ||
                             q.steps == LAST_ST) begin
                    d.err  = 1'b1;
                    d.st   = S_DONE;
                    d.done = 1'b1;
                end else begin
                    d.prev  = q.cur;
                    d.cur   = h_nxt;
                    d.steps = q.steps + 1'b1;
                    d.st    = S_READ;
                end
            end
            S_LINK: begin
                ram_we    = 1'b1;
                ram_waddr = q.r_prev;
                ram_wdata = hdr_pack(q.tail_hdr[ID_W-1:0],
                                     q.tail_hdr[ID_W+VER_W-1:ID_W], q.new_off);
                d.st      = S_WRITE;
            end
            S_WRITE: begin
                ram_we    = 1'b1;
                ram_waddr = q.new_off;
                ram_wdata = hdr_pack(q.app_id, q.ver,
                                     q.head ? q.tail_hdr[HDR_W-1:ID_W+VER_W] : '0);
                d.st      = S_DONE;
                d.done    = 1'b1;
            end
            S_DONE: d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy       = (q.st != S_IDLE);
    assign done       = q.done;
    assign found      = q.found;
    assign error      = q.err;
    assign res_offset = q.r_off;
    assign res_prev   = q.r_prev;
    assign res_ver    = q.r_ver;

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    p_busy_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy);
    p_found_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> (res_offset[1:0] == 2'b00 && res_offset >= BASE_A && res_offset <= TOP_A));
    p_no_found_on_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && error) |-> (!found && res_offset == '0));
    p_step_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.steps <= LAST_ST);
    p_write_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_waddr >= BASE_A && ram_waddr[1:0] == 2'b00));
endmodule

// File: tb/sim_ecap_walker.sv
module sim_ecap_walker;
    localparam int LIM = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_op = 1'b0;
    logic [15:0] cmd_id = '0;
    logic [3:0]  cmd_ver = '0;
    logic [11:0] cmd_offset = '0;
    logic [12:0] cmd_size = '0;
    logic        busy, done, found, error;
    logic [11:0] res_offset, res_prev;
    logic [3:0]  res_ver;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;

    logic [11:0] m_off [32];
    logic [15:0] m_id  [32];
    logic [3:0]  m_ver [32];
    int          n = 0;

    logic        g_found, g_err;
    logic [11:0] g_off, g_prev;
    logic [3:0]  g_ver;

    always #4 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    ecap_walker #(.STEP_LIMIT(LIM)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_id(cmd_id), .cmd_ver(cmd_ver), .cmd_offset(cmd_offset), .cmd_size(cmd_size),
        .busy(busy), .done(done), .found(found), .error(error),
        .res_offset(res_offset), .res_prev(res_prev), .res_ver(res_ver)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_done();
        int w = 0;
        while (done !== 1'b1 && w < 4000) begin
            @(negedge clk);
            w++;
        end
        if (done !== 1'b1) chk("R11 timeout", 32'd0, 32'd1);
        g_found = found; g_err = error; g_off = res_offset; g_prev = res_prev; g_ver = res_ver;
    endtask

    task automatic issue(input logic op, input logic [15:0] id, input logic [3:0] ver,
                         input logic [11:0] off, input logic [12:0] sz);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_id = id; cmd_ver = ver;
        cmd_offset = off; cmd_size = sz;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic run(input logic op, input logic [15:0] id, input logic [3:0] ver,
                       input logic [11:0] off, input logic [12:0] sz);
        issue(op, id, ver, off, sz);
        wait_done();
    endtask

    // Expected lookup result from the model chain
    task automatic check_find(input string req, input logic [15:0] id);
        int pos = -1;
        logic ef, ee; logic [11:0] eo, ep; logic [3:0] ev;
        for (int i = 0; i < n; i++) if (pos < 0 && id != 16'h0 && m_id[i] == id) pos = i;
        ef = 0; ee = 0; eo = 0; ep = 0; ev = 0;
        if (pos >= 0) begin
            if (pos + 1 > LIM) ee = 1;
            else begin ef = 1; eo = m_off[pos]; ep = (pos == 0) ? 12'h0 : m_off[pos-1]; ev = m_ver[pos]; end
        end else if (n > LIM) ee = 1;
        else if (n > 0) ep = m_off[n-1];
        run(1'b0, id, 4'h0, 12'h0, 13'h0);
        chk({req, " found"}, 32'(g_found), 32'(ef));
        chk({req, " error"}, 32'(g_err), 32'(ee));
        chk({req, " offset"}, 32'(g_off), 32'(eo));
        chk({req, " prev"}, 32'(g_prev), 32'(ep));
        chk({req, " version"}, 32'(g_ver), 32'(ev));
    endtask

    task automatic check_append(input string req, input logic [15:0] id, input logic [3:0] ver,
                                input logic [11:0] off, input logic [12:0] sz, input logic exp_err);
        logic [11:0] tail;
        tail = (n > 0) ? m_off[n-1] : 12'h0;
        run(1'b1, id, ver, off, sz);
        chk({req, " append error"}, 32'(g_err), 32'(exp_err));
        if (!exp_err) begin
            chk({req, " append offset"}, 32'(g_off), 32'(off));
            chk({req, " append prev"}, 32'(g_prev), 32'((off == 12'h100) ? 12'h0 : tail));
        end
    endtask

    initial begin
        while (cycles < 150000) @(negedge clk);
        chk("R11 watchdog", 32'd0, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset busy", 32'(busy), 32'd0);
        chk("R11 reset done", 32'(done), 32'd0);

        // R2: fresh space is an empty chain
        check_find("R2 empty", 16'h0010);
        // R9: non-head append into empty chain
        check_append("R9 empty non-head", 16'h0020, 4'h2, 12'h200, 13'd8, 1'b1);
        check_find("R9 still empty", 16'h0020);

        // R6/R1: head first, then descending offsets (R7)
        check_append("R6 head", 16'h0001, 4'h1, 12'h100, 13'd8, 1'b0);
        m_off[0] = 12'h100; m_id[0] = 16'h0001; m_ver[0] = 4'h1; n = 1;
        for (int k = 1; k < LIM; k++) begin
            logic [11:0] o;
            o = 12'(12'hF00 - k * 12'h80);
            check_append("R7 link", 16'(k + 1), 4'(k), o, 13'd16, 1'b0);
            m_off[n] = o; m_id[n] = 16'(k + 1); m_ver[n] = 4'(k); n++;
        end

        // R3/R1: every entry, R4 absent, R5 reserved
        for (int i = 0; i < n; i++) check_find("R3 R1 lookup", m_id[i]);
        check_find("R4 absent", 16'h7777);
        check_find("R5 reserved", 16'h0000);

        // R8: reject edges, chain untouched afterward
        check_append("R8 below base", 16'h0090, 4'h3, 12'h0FC, 13'd8, 1'b1);
        check_append("R8 unaligned", 16'h0091, 4'h3, 12'h302, 13'd8, 1'b1);
        check_append("R8 small size", 16'h0092, 4'h3, 12'h300, 13'd7, 1'b1);
        check_append("R8 end at 4K", 16'h0093, 4'h3, 12'hFF8, 13'd8, 1'b1);
        check_find("R8 unchanged", 16'h0000);
        check_find("R8 no entry", 16'h0093);

        // R6: rewrite head, link kept
        check_append("R6 rewrite", 16'h0055, 4'h9, 12'h100, 13'd8, 1'b0);
        m_id[0] = 16'h0055; m_ver[0] = 4'h9;
        check_find("R6 new head", 16'h0055);
        check_find("R6 old head gone", 16'h0001);
        check_find("R6 second", m_id[1]);

        // R11: request during busy is ignored
        issue(1'b0, m_id[n-1], 4'h0, 12'h0, 13'h0);
        chk("R11 busy", 32'(busy), 32'd1);
        cmd_valid = 1'b1; cmd_op = 1'b1; cmd_id = 16'h0066; cmd_ver = 4'h6;
        cmd_offset = 12'h300; cmd_size = 13'd8;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_done();
        chk("R11 result", 32'(g_off), 32'(m_off[n-1]));
        @(negedge clk);
        chk("R11 done pulse", 32'(done), 32'd0);
        chk("R11 idle", 32'(busy), 32'd0);
        check_find("R11 ignored", 16'h0066);

        // R10: step limit
        check_append("R10 at limit", 16'h00A0, 4'hA, 12'h180, 13'd8, 1'b0);
        m_off[n] = 12'h180; m_id[n] = 16'h00A0; m_ver[n] = 4'hA; n++;
        check_append("R10 past limit", 16'h00A1, 4'hB, 12'h1C0, 13'd8, 1'b1);
        check_find("R10 deep", 16'h00A0);
        check_find("R10 last ok", m_id[LIM-1]);
        check_find("R10 reserved", 16'h0000);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule